// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two mailbox interrupt flags of a two-port shared memory with a 12-bit address space. The two highest words of the address space act as doorbells. A write by one port to the word owned by the other port raises the other port's interrupt. A read of that word by the owning port clears its own interrupt. The block only watches each port's chip enable, write enable, output enable and address. It stores no data. The memory array sits elsewhere.

Each flag is a registered, active-low output that is driven both high and low. An access counts as one event, in the cycle where its last needed enable becomes active. An access that is held across many cycles still counts only once. When a set and a clear reach the same flag in the same cycle, the set wins. Reset is synchronous and active low, and it returns both flags to the inactive (high) level.

Top module: `dpmb_mailbox_irq`

## Requirements
- R1: While rst_n is low at a rising clock edge, both l_irq_n and r_irq_n are 1 after that edge.
- R2: A left write (l_ce_n=0, l_we_n=0) to address 0xFFF drives r_irq_n to 0 after the next rising edge.
- R3: A right write (r_ce_n=0, r_we_n=0) to address 0xFFE drives l_irq_n to 0 after the next rising edge.
- R4: A right read (r_ce_n=0, r_we_n=1, r_oe_n=0) of address 0xFFF returns r_irq_n to 1 after the next rising edge.
- R5: A left read (l_ce_n=0, l_we_n=1, l_oe_n=0) of address 0xFFE returns l_irq_n to 1 after the next rising edge.
- R6: An access that lacks any one of chip enable, read mode or output enable does not clear a flag, and neither does a read of the other mailbox word.
- R7: A write to any other address does not set a flag, and neither does a port's write to its own mailbox word.
- R8: When a set and a clear of the same flag arrive in the same cycle, the flag ends up at 0.
- R9: An access takes effect once, in the cycle where its last enable becomes active. Holding an access active does not repeat it, and it only acts again after it has been released and asserted anew.
- R10: Without a set or clear event, each flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write enable, active low (1 = read) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 12 | Left address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write enable, active low (1 = read) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 12 | Right address |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
A set or a clear shows up on the flag pin one rising edge after the cycle in which the access becomes complete. This holds because the edge detector and the flag register update on the same edge. The bench drives every access at a falling edge and samples the flags at the next falling edge, so the sample lands exactly one edge after the stimulus. It then releases the port for one more cycle, so that the next access registers as a new event. For the held-access cases, the bench samples several falling edges in a row while the access stays active, to show that nothing repeats.

// File: rtl/dpmb_pkg.sv
// Package: shared width and the request type passed from the port decoders
// to the flag registers.
package dpmb_pkg;
    localparam int DPMB_ADDR_W = 12;

    // Per-flag event pair, each bit a one-cycle pulse.
    typedef struct packed {
        logic set;
        logic clr;
    } flag_req_t;
endpackage

// File: rtl/dpmb_port_decode.sv
// Module: dpmb_port_decode
// Watches one port's control signals and address.
// - Gives a one-cycle pulse when a write to WR_ADDR (the other side's word)
//   becomes complete.
// - Gives a one-cycle pulse when a full read of RD_ADDR (this side's word)
//   becomes complete.
// Assumes the controls are synchronous to clk and active low.
module dpmb_port_decode #(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] WR_ADDR = '1,
    parameter logic [ADDR_W-1:0] RD_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              set_pulse,
    output logic              clr_pulse
);
    logic wr_hit, rd_hit;
    logic wr_hit_q, rd_hit_q;

    // Qualify complete accesses that match a mailbox word.
    always_comb begin
        wr_hit = !ce_n && !we_n && (addr == WR_ADDR);
        rd_hit = !ce_n && we_n && !oe_n && (addr == RD_ADDR);
    end

    // Remember last cycle's match so that a held access fires once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hit_q <= 1'b0;
            rd_hit_q <= 1'b0;
        end else begin
            wr_hit_q <= wr_hit;
            rd_hit_q <= rd_hit;
        end
    end

    // Event fires in the cycle the last enable completes the access.
    assign set_pulse = wr_hit && !wr_hit_q;
    assign clr_pulse = rd_hit && !rd_hit_q;

    AST_SET_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> !set_pulse); // R9
    AST_CLR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse); // R9
endmodule

// File: rtl/dpmb_flag.sv
// Module: dpmb_flag
// Holds one active-low interrupt flag. A set drives it low and a clear
// drives it high. When both arrive in the same cycle, the set wins.
// Assumes the request bits are single-cycle pulses.
module dpmb_flag (
    input  logic                clk,
    input  logic                rst_n,
    input  dpmb_pkg::flag_req_t req,
    output logic                irq_n
);
    // Update the flag, giving the set priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_n <= 1'b1;
        else if (req.set)  irq_n <= 1'b0;
        else if (req.clr)  irq_n <= 1'b1;
    end

    AST_SET_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        req.set |=> !irq_n); // R8
    AST_CLR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (req.clr && !req.set) |=> irq_n); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req.clr && !req.set) |=> $stable(irq_n)); // R10
endmodule

// File: rtl/dpmb_mailbox_irq.sv
// Module: dpmb_mailbox_irq (top)
// Builds the mailbox interrupts for a two-port memory.
// - The top word belongs to the right port: a left write sets r_irq_n and a
//   right read clears it.
// - The word below it belongs to the left port: a right write sets l_irq_n
//   and a left read clears it.
// Assumes both ports run synchronous to clk.
module dpmb_mailbox_irq #(
    parameter int ADDR_W = dpmb_pkg::DPMB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

    logic l_set_r, l_clr_l, r_set_l, r_clr_r;
    dpmb_pkg::flag_req_t l_req, r_req;

    dpmb_port_decode #(.ADDR_W(ADDR_W), .WR_ADDR(R_BOX), .RD_ADDR(L_BOX)) u_left_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(l_ce_n), .we_n(l_we_n), .oe_n(l_oe_n),
        .addr(l_addr), .set_pulse(l_set_r), .clr_pulse(l_clr_l)
    );

    dpmb_port_decode #(.ADDR_W(ADDR_W), .WR_ADDR(L_BOX), .RD_ADDR(R_BOX)) u_right_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(r_ce_n), .we_n(r_we_n), .oe_n(r_oe_n),
        .addr(r_addr), .set_pulse(r_set_l), .clr_pulse(r_clr_r)
    );

    // Route each set from the opposite port and each clear from the owner.
    always_comb begin
        l_req = '{set: r_set_l, clr: l_clr_l};
        r_req = '{set: l_set_r, clr: r_clr_r};
    end

    dpmb_flag u_left_flag  (.clk(clk), .rst_n(rst_n), .req(l_req), .irq_n(l_irq_n));
    dpmb_flag u_right_flag (.clk(clk), .rst_n(rst_n), .req(r_req), .irq_n(r_irq_n));

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n)); // R1
    AST_LEFT_WRITE_SETS_R: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && !l_we_n && l_addr == R_BOX && $past(l_ce_n || l_we_n || l_addr != R_BOX))
        |=> !r_irq_n); // R2
    AST_RIGHT_WRITE_SETS_L: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n && !r_we_n && r_addr == L_BOX && $past(r_ce_n || r_we_n || r_addr != L_BOX))
        |=> !l_irq_n); // R3
endmodule

// File: tb/dpmb_mailbox_irq_tb.sv
// Bench: sweeps every address on both ports and every control combination,
// and checks set priority and the once-per-access behaviour.
module dpmb_mailbox_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int RBOX = (1 << AW) - 1;
    localparam int LBOX = (1 << AW) - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_ce_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1;
    logic r_ce_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpmb_mailbox_irq dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_l();
        l_ce_n = 1'b1; l_we_n = 1'b1; l_oe_n = 1'b1; l_addr = '0;
    endtask
    task automatic idle_r();
        r_ce_n = 1'b1; r_we_n = 1'b1; r_oe_n = 1'b1; r_addr = '0;
    endtask

    // Drive one left access at a falling edge and wait one edge (sample point).
    task automatic drive_l(input logic ce, input logic we, input logic oe, input int a);
        l_ce_n = ce; l_we_n = we; l_oe_n = oe; l_addr = AW'(a);
        @(negedge clk);
    endtask
    task automatic drive_r(input logic ce, input logic we, input logic oe, input int a);
        r_ce_n = ce; r_we_n = we; r_oe_n = oe; r_addr = AW'(a);
        @(negedge clk);
    endtask
    task automatic release_both();
        idle_l(); idle_r();
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; fails++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 left reset", l_irq_n, 1'b1);
        chk("R1 right reset", r_irq_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R7 sweep of every left write address
        for (int a = 0; a < (1 << AW); a++) begin
            drive_l(1'b0, 1'b0, 1'b1, a);
            chk("R2/R7 right flag after left write", r_irq_n, (a == RBOX) ? 1'b0 : 1'b1);
            chk("R7 left own word", l_irq_n, 1'b1);
            release_both();
            if (a == RBOX) begin
                drive_r(1'b0, 1'b1, 1'b0, RBOX);
                chk("R4 right read clears", r_irq_n, 1'b1);
                release_both();
            end
        end

        // R3/R7 sweep of every right write address
        for (int a = 0; a < (1 << AW); a++) begin
            drive_r(1'b0, 1'b0, 1'b1, a);
            chk("R3/R7 left flag after right write", l_irq_n, (a == LBOX) ? 1'b0 : 1'b1);
            chk("R7 right own word", r_irq_n, 1'b1);
            release_both();
            if (a == LBOX) begin
                drive_l(1'b0, 1'b1, 1'b0, LBOX);
                chk("R5 left read clears", l_irq_n, 1'b1);
                release_both();
            end
        end

        // R4/R5/R6 sweep of all control combinations on the clearing side
        for (int c = 0; c < 8; c++) begin
            logic ce, we, oe, clr;
            ce = c[2]; we = c[1]; oe = c[0];
            clr = !ce && we && !oe;
            drive_l(1'b0, 1'b0, 1'b1, RBOX); release_both();
            drive_r(1'b0, 1'b0, 1'b1, LBOX); release_both();
            drive_r(ce, we, oe, RBOX);
            chk("R4/R6 right flag vs controls", r_irq_n, clr);
            release_both();
            drive_l(ce, we, oe, LBOX);
            chk("R5/R6 left flag vs controls", l_irq_n, clr);
            release_both();
            drive_r(1'b0, 1'b1, 1'b0, RBOX); release_both();
            drive_l(1'b0, 1'b1, 1'b0, LBOX); release_both();
        end

        // R6: a read of the other side's word does not clear
        drive_l(1'b0, 1'b0, 1'b1, RBOX); release_both();
        drive_r(1'b0, 1'b1, 1'b0, LBOX);
        chk("R6 right reads left word", r_irq_n, 1'b0);
        release_both();
        chk("R10 right flag holds", r_irq_n, 1'b0);

        // R8: set and clear in the same cycle
        l_ce_n = 1'b0; l_we_n = 1'b0; l_addr = AW'(RBOX);
        drive_r(1'b0, 1'b1, 1'b0, RBOX);
        chk("R8 set wins on low flag", r_irq_n, 1'b0);
        release_both();
        drive_r(1'b0, 1'b1, 1'b0, RBOX);
        chk("R4 clear before R8", r_irq_n, 1'b1);
        release_both();
        r_ce_n = 1'b0; r_we_n = 1'b0; r_addr = AW'(LBOX);
        drive_l(1'b0, 1'b1, 1'b0, LBOX);
        chk("R8 set wins on high flag", l_irq_n, 1'b0);
        release_both();
        drive_l(1'b0, 1'b1, 1'b0, LBOX); release_both();

        // R9: a held read acts once, a fresh write sets again
        drive_l(1'b0, 1'b0, 1'b1, RBOX); release_both();
        drive_r(1'b0, 1'b1, 1'b0, RBOX);
        chk("R9 held read clears once", r_irq_n, 1'b1);
        drive_l(1'b0, 1'b0, 1'b1, RBOX);
        chk("R9 set during held read", r_irq_n, 1'b0);
        idle_l();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9 held read does not repeat", r_irq_n, 1'b0);
        end
        release_both();
        drive_r(1'b0, 1'b1, 1'b0, RBOX);
        chk("R9 fresh read clears", r_irq_n, 1'b1);
        release_both();

        // R9: the last enable (write strobe) times the event
        drive_l(1'b0, 1'b1, 1'b1, RBOX);
        chk("R9 no event before write strobe", r_irq_n, 1'b1);
        drive_l(1'b0, 1'b0, 1'b1, RBOX);
        chk("R9 event on last enable", r_irq_n, 1'b0);
        release_both();
        drive_r(1'b0, 1'b1, 1'b0, RBOX); release_both();
        chk("R4 final clear", r_irq_n, 1'b1);
        chk("R10 left flag idle", l_irq_n, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule